// File: doc/BRIEF.md
# Watchdog and Oscillator Settle Timer

This block shares one down-counting chain between two jobs. The chain is a prescaler followed by a counter, both 8 bits wide by default, and both advance on the instruction-cycle tick. After a wakeup from halt, the chain times a fixed settle window of 2^PRE_W ticks (256 by default). Instruction execution stays blocked until that window ends, so the oscillator has time to stabilise. During normal running the same chain acts as a watchdog. Software enables it once after each reset and must then keep reloading the counter. If the counter runs out, the block issues a one-cycle watchdog reset pulse.

Two synchronous reset causes act on the block. An external reset reloads the chain, drops the enable and its write lock, and aborts any settle window in progress. A brown-out reset also reloads the chain and drops the enable and lock, but it starts a settle window of its own. An external reset beats a brown-out reset and a wakeup that arrive in the same cycle. The asynchronous `rst_ni` is the power-up reset.

Top module: `wdg_osc_guard`

## Requirements
- R1: After `rst_ni` the chain holds all ones, `run_o` is 1, `wdog_rst_o` is 0, and the watchdog is disabled, so an underflow before any enable write gives no pulse.
- R2: The prescaler decrements once per cycle with `tick_i` high. The counter decrements only when the prescaler wraps from 0 to all ones. With `tick_i` low nothing advances, so a settle window stretches by exactly the number of missing ticks.
- R3: `wake_i` reloads the chain to all ones and takes `run_o` low in the next cycle. `run_o` returns high in the cycle after the 256th tick that follows the wakeup edge.
- R4: A wakeup that arrives during a settle window restarts the full window from that wakeup.
- R5: `brownout_i` reloads the chain, clears the enable and its lock, and starts a settle window with the same timing as R3. After it, an underflow gives no pulse until a new enable write is made.
- R6: `ext_rst_i` reloads the chain and clears the enable and its lock. `run_o` is 1 in the next cycle, so any settle window in progress is cancelled. It takes priority over `brownout_i` and `wake_i` in the same cycle.
- R7: A write with `cfg_we_i` high sets the enable to `cfg_en_i`, which is bit 0 of the watchdog register. Only the first such write after an external, brown-out or power-up reset takes effect. Later writes are ignored.
- R8: `cnt_we_i` loads `cnt_wdata_i` into the counter and leaves the prescaler alone. A counter write in the same cycle as a prescaler wrap wins over both the decrement and the underflow.
- R9: An underflow occurs when the prescaler wraps while the counter is 0. With the enable set, an underflow drives `wdog_rst_o` high for exactly one cycle. The counter then continues from all ones. Writing value v while the prescaler holds all ones gives the pulse 256·(v+1) ticks later, unless the counter is written again first.
- R10: While the enable is clear, `wdog_rst_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| tick_i | input | 1 | Instruction-cycle tick, advances the chain |
| wake_i | input | 1 | Valid wakeup from halt, starts a settle window |
| brownout_i | input | 1 | Brown-out reset cause, starts a settle window |
| ext_rst_i | input | 1 | External reset cause, cancels a settle window |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write value |
| cfg_we_i | input | 1 | Watchdog register write strobe |
| cfg_en_i | input | 1 | Enable value written (register bit 0) |
| run_o | output | 1 | High when instruction execution may proceed |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The chain has no visible state of its own. A wrong prescaler or counter value therefore shows up only as a shift in the cycle where `run_o` rises or `wdog_rst_o` pulses. That shift can appear up to 2^PRE_W·2^CNT_W ticks after the fault, so the stimulus writes small counter values with the prescaler at a known phase. A wrong enable or lock bit shows as a pulse that is missing or unexpected at the next underflow, which is at most 256 ticks away once the counter is written with 0. The scoreboard compares every pulse and every rise of `run_o` against the exact cycle it predicts, and it flags any such event it did not predict.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned PRE_W_DEF = 8;
  localparam int unsigned CNT_W_DEF = 8;

  // resolved reload cause, highest priority last
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_WAKE  = 2'd1,
    EV_BROWN = 2'd2,
    EV_EXT   = 2'd3
  } load_ev_e;
endpackage

// File: rtl/wdg_chain.sv
module wdg_chain #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic             wrap_o,
  output logic             uflow_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o  = tick_i & ~load_i & (pre_q == '0);
  assign uflow_o = wrap_o & ~cnt_we_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '1;
      cnt_q <= '1;
    end else if (load_i) begin
      pre_q <= '1;
      cnt_q <= '1;
    end else begin
      if (tick_i) pre_q <= pre_q - 1'b1;
      // write beats decrement; decrement from 0 wraps to all ones
      if (cnt_we_i)    cnt_q <= cnt_wdata_i;
      else if (wrap_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_enable.sv
module wdg_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  logic en_i,
  output logic en_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      en_o   <= 1'b0;
      lock_q <= 1'b0;
    end else if (we_i && !lock_q) begin
      en_o   <= en_i;
      lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_settle.sv
module wdg_settle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cancel_i,
  input  logic start_i,
  input  logic wrap_i,
  output logic busy_o
);
  // window ends on first prescaler wrap after a full reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_o <= 1'b0;
    else if (cancel_i) busy_o <= 1'b0;
    else if (start_i)  busy_o <= 1'b1;
    else if (wrap_i)   busy_o <= 1'b0;
  end
endmodule

// File: rtl/wdg_osc_guard.sv
module wdg_osc_guard
  import wdg_pkg::*;
#(
  parameter int unsigned PRE_W = PRE_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wake_i,
  input  logic             brownout_i,
  input  logic             ext_rst_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  output logic             run_o,
  output logic             wdog_rst_o
);
  load_ev_e ev;
  logic     load, clr, start, cancel;
  logic     wrap_w, uflow_w, en_w, busy_w;
  logic     pulse_q;

  always_comb begin
    if (ext_rst_i)       ev = EV_EXT;
    else if (brownout_i) ev = EV_BROWN;
    else if (wake_i)     ev = EV_WAKE;
    else                 ev = EV_NONE;
  end

  assign load   = (ev != EV_NONE);
  assign clr    = (ev == EV_EXT) || (ev == EV_BROWN);
  assign start  = (ev == EV_BROWN) || (ev == EV_WAKE);
  assign cancel = (ev == EV_EXT);

  wdg_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .tick_i      (tick_i),
    .cnt_we_i    (cnt_we_i),
    .cnt_wdata_i (cnt_wdata_i),
    .wrap_o      (wrap_w),
    .uflow_o     (uflow_w)
  );

  wdg_enable u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .we_i   (cfg_we_i),
    .en_i   (cfg_en_i),
    .en_o   (en_w)
  );

  wdg_settle u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cancel_i (cancel),
    .start_i  (start),
    .wrap_i   (wrap_w),
    .busy_o   (busy_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= uflow_w & en_w & ~busy_w;
  end

  assign run_o      = ~busy_w;
  assign wdog_rst_o = pulse_q;
endmodule

// File: rtl/wdg_osc_guard_chk.sv
module wdg_osc_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wake_i,
  input logic brownout_i,
  input logic ext_rst_i,
  input logic cfg_we_i,
  input logic en_i,
  input logic run_o,
  input logic wdog_rst_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_q <= 1'b0;
    else if (ext_rst_i || brownout_i) seen_q <= 1'b0;
    else if (cfg_we_i)                seen_q <= 1'b1;
  end

  // R6
  ext_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> run_o && !wdog_rst_o);

  // R3
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !ext_rst_i) |=> !run_o);

  // R5
  brown_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brownout_i && !ext_rst_i) |=> !run_o && !en_i);

  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wdog_rst_o);

  // R7
  enable_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ext_rst_i && !brownout_i) |=> $stable(en_i));

  // R2
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !run_o && !ext_rst_i) |=> !run_o && !wdog_rst_o);
endmodule

bind wdg_osc_guard wdg_osc_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wake_i     (wake_i),
  .brownout_i (brownout_i),
  .ext_rst_i  (ext_rst_i),
  .cfg_we_i   (cfg_we_i),
  .en_i       (en_w),
  .run_o      (run_o),
  .wdog_rst_o (wdog_rst_o)
);

// File: tb/wdg_osc_guard_tb.sv
`timescale 1ns/1ps
module wdg_osc_guard_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wake_i = 1'b0, brownout_i = 1'b0, ext_rst_i = 1'b0;
  logic       cnt_we_i = 1'b0, cfg_we_i = 1'b0, cfg_en_i = 1'b0;
  logic [7:0] cnt_wdata_i = 8'h00;
  logic       run_o, wdog_rst_o;

  always #2 clk = ~clk;

  wdg_osc_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wake_i(wake_i),
    .brownout_i(brownout_i), .ext_rst_i(ext_rst_i), .cnt_we_i(cnt_we_i),
    .cnt_wdata_i(cnt_wdata_i), .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i),
    .run_o(run_o), .wdog_rst_o(wdog_rst_o)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, pulses = 0;
  bit mon_on = 1'b0;
  logic run_prev = 1'b1;

  typedef struct {bit is_run; longint at; string req;} ev_t;
  ev_t exp_q[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(bit is_run, longint at, string req);
    ev_t e;
    e.is_run = is_run; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(bit is_run);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, is_run ? "R3" : "R10", is_run ? "unexpected run rise" : "unexpected pulse",
          cyc, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.is_run == is_run && e.at == cyc, e.req,
          is_run ? "run rise cycle" : "pulse cycle", cyc, e.at);
    end
  endtask

  // monitor: pops scoreboard on each observed event
  always @(negedge clk) begin
    if (mon_on) begin
      while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
        ev_t e;
        e = exp_q.pop_front();
        chk(1'b0, e.req, "event missing", -1, e.at);
      end
      if (wdog_rst_o) begin
        pulses++;
        observe(1'b0);
      end
      if (run_o && !run_prev) observe(1'b1);
      run_prev = run_o;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic to_cyc(longint n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr_cnt(logic [7:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v;
    step();
    cnt_we_i = 1'b0;
  endtask

  // ext reset with ticks stopped, one enable write; prescaler all ones at t0
  task automatic clean(bit en, output longint t0);
    tick_i = 1'b0; ext_rst_i = 1'b1;
    step();
    ext_rst_i = 1'b0; cfg_we_i = 1'b1; cfg_en_i = en;
    step();
    cfg_we_i = 1'b0;
    t0 = cyc;
    tick_i = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint t0, c;
    int p0;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk(run_o == 1'b1, "R1", "run_o after reset", run_o, 1);
    chk(wdog_rst_o == 1'b0, "R1", "wdog_rst_o after reset", wdog_rst_o, 0);
    run_prev = run_o;
    mon_on = 1'b1;

    // R1 disabled at power-up: underflow at c+256 gives no pulse
    tick_i = 1'b1; c = cyc; p0 = pulses;
    wr_cnt(8'd0);
    to_cyc(c + 300);
    chk(pulses == p0, "R1", "pulses while never enabled", pulses - p0, 0);

    // R10 enable written 0
    clean(1'b0, t0); p0 = pulses;
    wr_cnt(8'd0);
    to_cyc(t0 + 600);
    chk(pulses == p0, "R10", "pulses while disabled", pulses - p0, 0);

    // R9 v=2 -> pulse 768 ticks on
    clean(1'b1, t0); p0 = pulses;
    wr_cnt(8'd2);
    expect_ev(1'b0, t0 + 768, "R9");
    to_cyc(t0 + 780);
    chk(pulses == p0 + 1, "R9", "pulse count v=2", pulses - p0, 1);
    chk(run_o == 1'b1, "R9", "run_o unaffected by pulse", run_o, 1);

    // R8 counter write keeps prescaler phase
    clean(1'b1, t0);
    to_cyc(t0 + 99);
    wr_cnt(8'd1);
    expect_ev(1'b0, t0 + 512, "R8");
    to_cyc(t0 + 520);

    // R8 write coinciding with wrap at counter 0 wins
    clean(1'b1, t0);
    wr_cnt(8'd0);
    to_cyc(t0 + 255);
    wr_cnt(8'd0);
    expect_ev(1'b0, t0 + 512, "R8");
    to_cyc(t0 + 520);

    // R9 periodic reload keeps it quiet until reloads stop
    clean(1'b1, t0); p0 = pulses;
    for (int k = 0; k < 5; k++) begin
      to_cyc(t0 + 300 * k);
      wr_cnt(8'd1);
    end
    chk(pulses == p0, "R9", "no pulse while serviced", pulses - p0, 0);
    expect_ev(1'b0, t0 + 1536, "R9");
    to_cyc(t0 + 1550);

    // R7 second write ignored (enable stays 1)
    clean(1'b1, t0);
    cfg_we_i = 1'b1; cfg_en_i = 1'b0; cnt_we_i = 1'b1; cnt_wdata_i = 8'd0;
    step();
    cfg_we_i = 1'b0; cnt_we_i = 1'b0;
    expect_ev(1'b0, t0 + 256, "R7");
    to_cyc(t0 + 270);

    // R7 second write ignored (enable stays 0)
    clean(1'b0, t0); p0 = pulses;
    cfg_we_i = 1'b1; cfg_en_i = 1'b1; cnt_we_i = 1'b1; cnt_wdata_i = 8'd0;
    step();
    cfg_we_i = 1'b0; cnt_we_i = 1'b0;
    to_cyc(t0 + 300);
    chk(pulses == p0, "R7", "late enable write ignored", pulses - p0, 0);

    // R6 ext reset clears lock so a new enable write works
    clean(1'b1, t0);
    wr_cnt(8'd0);
    expect_ev(1'b0, t0 + 256, "R6");
    to_cyc(t0 + 270);

    // R3 settle window
    c = cyc; wake_i = 1'b1;
    expect_ev(1'b1, c + 257, "R3");
    step();
    wake_i = 1'b0;
    chk(run_o == 1'b0, "R3", "run_o after wake", run_o, 0);
    to_cyc(c + 256);
    chk(run_o == 1'b0, "R3", "run_o one cycle before end", run_o, 0);
    to_cyc(c + 260);
    chk(run_o == 1'b1, "R3", "run_o after window", run_o, 1);

    // R2 ten missing ticks stretch the window by ten
    c = cyc; wake_i = 1'b1;
    expect_ev(1'b1, c + 267, "R2");
    step();
    wake_i = 1'b0;
    to_cyc(c + 50); tick_i = 1'b0;
    to_cyc(c + 60); tick_i = 1'b1;
    to_cyc(c + 262);
    chk(run_o == 1'b0, "R2", "run_o held by missing ticks", run_o, 0);
    to_cyc(c + 270);

    // R4 second wake restarts
    c = cyc; wake_i = 1'b1;
    step();
    wake_i = 1'b0;
    to_cyc(c + 100); wake_i = 1'b1;
    step();
    wake_i = 1'b0;
    expect_ev(1'b1, c + 357, "R4");
    to_cyc(c + 300);
    chk(run_o == 1'b0, "R4", "run_o past first window end", run_o, 0);
    to_cyc(c + 360);

    // R6 ext reset cancels window
    c = cyc; wake_i = 1'b1;
    step();
    wake_i = 1'b0;
    to_cyc(c + 50); ext_rst_i = 1'b1;
    expect_ev(1'b1, c + 51, "R6");
    step();
    ext_rst_i = 1'b0;
    chk(run_o == 1'b1, "R6", "run_o after cancel", run_o, 1);
    to_cyc(c + 300);

    // R6 ext beats brown-out and wake in same cycle
    c = cyc; ext_rst_i = 1'b1; brownout_i = 1'b1; wake_i = 1'b1;
    step();
    ext_rst_i = 1'b0; brownout_i = 1'b0; wake_i = 1'b0;
    chk(run_o == 1'b1, "R6", "run_o after ext+brownout", run_o, 1);
    to_cyc(c + 10);
    chk(run_o == 1'b1, "R6", "run_o stays high", run_o, 1);

    // R5 brown-out: window, enable cleared, lock cleared
    clean(1'b1, t0);
    c = cyc; brownout_i = 1'b1;
    expect_ev(1'b1, c + 257, "R5");
    step();
    brownout_i = 1'b0;
    chk(run_o == 1'b0, "R5", "run_o after brown-out", run_o, 0);
    to_cyc(c + 257);
    p0 = pulses;
    wr_cnt(8'd0);
    to_cyc(c + 520);
    chk(pulses == p0, "R5", "enable cleared by brown-out", pulses - p0, 0);
    cfg_we_i = 1'b1; cfg_en_i = 1'b1; cnt_we_i = 1'b1; cnt_wdata_i = 8'd0;
    step();
    cfg_we_i = 1'b0; cnt_we_i = 1'b0;
    expect_ev(1'b0, c + 769, "R5");
    to_cyc(c + 780);

    repeat (5) step();
    chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule